// File: doc/BRIEF.md
# Self-Reloading Programmable Clock Divider

This block divides its input clock by a ratio from 2 to 2^W (2 to 64 at the default width of 6). It is built around a small universal counter with four modes: load, count down, count up and hold. The counter's active-low terminal-count signal is fed back into its own mode select. When the count reaches its terminal value, the select falls into load mode. The next rising edge then reloads the preset by itself, and counting resumes. No comparator is needed. The divide ratio is one more than the number of counting steps, so a preset of P gives a period of P+1 input clocks.

The terminal-count signal is also the block's output, `pulse_n`. It is low for exactly one input clock in every period. A build parameter picks the count direction. Counting down, the preset is the ratio minus one. Counting up, the preset is the one's complement of the ratio minus one, and the counter climbs to all ones. A preset that would make the counter stay at terminal count forever is replaced at load time by the smallest legal ratio.

Top module: `prog_clk_div`

## Requirements
- R1: While `rst_n` is low, `count` holds the terminal value (0 when counting down, all ones when counting up) and `pulse_n` is low. The first rising edge after release loads the preset into `count`.
- R2: `pulse_n` is low for exactly one input clock at a time. It is never low on two clock edges in a row.
- R3: With COUNT_UP=0 and a preset P in 1..2^W-1, successive low pulses on `pulse_n` are P+1 input clocks apart. For example, P=1 divides by 2, P=35 by 36 and P=63 by 64.
- R4: With COUNT_UP=1, a preset D that is not all ones makes the low pulses 2^W-D clocks apart. So D = ~(ratio-1) selects that ratio, and D=0 divides by 2^W.
- R5: `preset` is sampled only on the rising edge where `pulse_n` is low. A change made between two reloads leaves the period in progress unchanged and takes effect at the next reload.
- R6: A preset that would pin the counter at terminal count is replaced by the ratio-2 value. With COUNT_UP=0, a preset of 0 loads 1. With COUNT_UP=1, a preset of all ones loads all ones minus 1. Either way the period is 2.
- R7: Between reloads, `count` moves one step per clock toward the terminal value (down by 1, or up by 1). `pulse_n` is low exactly when `count` equals that terminal value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| preset | input | W | Reload value that sets the divide ratio |
| pulse_n | output | 1 | Active-low terminal-count pulse, one clock wide per period |
| count | output | W | Present counter value |

## Verification
Several rules are checked by the assertions on every clock. The output is low for a single cycle only. Each low cycle is followed by a count equal to the sampled and guarded preset. Every high cycle moves the count by one step toward terminal. The gap between pulses never exceeds 2^W clocks. Only the bench scenarios can show the whole-period behaviour end to end: the exact period for every preset in both directions, the guarded zero case, and a mid-period preset change being deferred to the next reload.

// File: rtl/div_pkg.sv
package div_pkg;

   // Mode select: bit 0 is the first select, bit 1 is the second select.
   typedef enum logic [1:0] {
      MODE_LOAD = 2'b00,
      MODE_DOWN = 2'b01,
      MODE_UP   = 2'b10,
      MODE_HOLD = 2'b11
   } mode_e;

endpackage

// File: rtl/div_preset_guard.sv
module div_preset_guard #(
   parameter int W        = 6,
   parameter bit COUNT_UP = 1'b0
) (
   input  logic [W-1:0] preset,
   output logic [W-1:0] load_val
);
   localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
   localparam logic [W-1:0] ONE      = {{(W-1){1'b0}}, 1'b1};

   generate
      if (COUNT_UP) begin : g_up
         // all ones would sit on terminal count; substitute the ratio-2 value
         always_comb load_val = (preset == ALL_ONES) ? ~ONE : preset;
      end else begin : g_down
         // zero would sit on terminal count; substitute the ratio-2 value
         always_comb load_val = (preset == '0) ? ONE : preset;
      end
   endgenerate
endmodule

// File: rtl/div_term_detect.sv
module div_term_detect #(
   parameter int W        = 6,
   parameter bit COUNT_UP = 1'b0
) (
   input  logic [W-1:0] count,
   output logic         tc_n
);
   generate
      if (COUNT_UP) begin : g_up
         always_comb tc_n = ~(&count);
      end else begin : g_down
         always_comb tc_n = |count;
      end
   endgenerate
endmodule

// File: rtl/div_mode_feedback.sv
module div_mode_feedback
   import div_pkg::*;
#(
   parameter bit COUNT_UP = 1'b0
) (
   input  logic  tc_n,
   output mode_e mode
);
   generate
      if (COUNT_UP) begin : g_up
         // first select tied low, feedback on second select
         always_comb mode = tc_n ? MODE_UP : MODE_LOAD;
      end else begin : g_down
         // second select tied low, feedback on first select
         always_comb mode = tc_n ? MODE_DOWN : MODE_LOAD;
      end
   endgenerate
endmodule

// File: rtl/div_core_counter.sv
module div_core_counter
   import div_pkg::*;
#(
   parameter int          W       = 6,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  mode_e        mode,
   input  logic [W-1:0] load_val,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] STEP = {{(W-1){1'b0}}, 1'b1};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= RST_VAL;
      end else begin
         case (mode)
            MODE_LOAD: count <= load_val;
            MODE_DOWN: count <= count - STEP;
            MODE_UP:   count <= count + STEP;
            MODE_HOLD: count <= count;
            default:   count <= count;
         endcase
      end
   end
endmodule

// File: rtl/prog_clk_div.sv
module prog_clk_div
   import div_pkg::*;
#(
   parameter int W        = 6,
   parameter bit COUNT_UP = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] preset,
   output logic         pulse_n,
   output logic [W-1:0] count
);
   localparam logic [W-1:0] TERM_VAL = COUNT_UP ? {W{1'b1}} : {W{1'b0}};

   generate
      if (W < 2 || W > 16) begin : g_bad_width
         $error("prog_clk_div: W must lie in 2..16");
      end
   endgenerate

   logic [W-1:0] load_val;
   logic         tc_n;
   mode_e        mode;

   div_preset_guard #(.W(W), .COUNT_UP(COUNT_UP)) u_guard (
      .preset   (preset),
      .load_val (load_val)
   );

   div_core_counter #(.W(W), .RST_VAL(TERM_VAL)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode     (mode),
      .load_val (load_val),
      .count    (count)
   );

   div_term_detect #(.W(W), .COUNT_UP(COUNT_UP)) u_tc (
      .count (count),
      .tc_n  (tc_n)
   );

   div_mode_feedback #(.COUNT_UP(COUNT_UP)) u_fb (
      .tc_n (tc_n),
      .mode (mode)
   );

   assign pulse_n = tc_n;
endmodule

// File: rtl/div_chk.sv
module div_chk #(
   parameter int W        = 6,
   parameter bit COUNT_UP = 1'b0
) (
   input logic         clk,
   input logic         rst_n,
   input logic [W-1:0] preset,
   input logic         pulse_n,
   input logic [W-1:0] count
);
   localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
   localparam logic [W-1:0] BAD  = COUNT_UP ? {W{1'b1}} : {W{1'b0}};
   localparam logic [W-1:0] SAFE = COUNT_UP ? ~ONE : ONE;

   logic [W-1:0] exp_load;
   always_comb exp_load = (preset == BAD) ? SAFE : preset;

   function automatic logic [W-1:0] next_step(input logic [W-1:0] v);
      return COUNT_UP ? v + ONE : v - ONE;
   endfunction

   logic [W:0] gap;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        gap <= '0;
      else if (!pulse_n) gap <= '0;
      else               gap <= gap + 1'b1;
   end

   // R2: the low pulse lasts one clock only
   a_r2_one_cycle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_n |=> pulse_n);

   // R5, R6: a low cycle reloads the sampled, guarded preset
   a_r5_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
      !pulse_n |=> count == $past(exp_load));

   // R7: one step per clock toward terminal between reloads
   a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      pulse_n |=> count == next_step($past(count)));

   // R3, R4: never more than 2^W clocks between pulses
   a_r3_period_bound: assert property (@(posedge clk) disable iff (!rst_n)
      gap <= (W+1)'((1 << W) - 1));
endmodule

bind prog_clk_div div_chk #(.W(W), .COUNT_UP(COUNT_UP)) u_div_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .preset  (preset),
   .pulse_n (pulse_n),
   .count   (count)
);

// File: tb/test_prog_clk_div.sv
module test_prog_clk_div;
   localparam int W = 6;
   localparam logic [W-1:0] ONES = {W{1'b1}};

   typedef struct {
      int    ratio;
      string tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] preset_dn = '0;
   logic [W-1:0] preset_up = '0;
   logic         pulse_dn, pulse_up;
   logic [W-1:0] count_dn, count_up;

   int   n_chk = 0;
   int   n_fail = 0;
   exp_t q_dn[$];
   exp_t q_up[$];
   int   sl_dn = 0, sl_up = 0;
   bit   mon_dn = 1'b0, mon_up = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   prog_clk_div #(.W(W), .COUNT_UP(1'b0)) i_prog_clk_div (
      .clk(clk), .rst_n(rst_n), .preset(preset_dn),
      .pulse_n(pulse_dn), .count(count_dn));

   prog_clk_div #(.W(W), .COUNT_UP(1'b1)) i_prog_clk_div_up (
      .clk(clk), .rst_n(rst_n), .preset(preset_up),
      .pulse_n(pulse_up), .count(count_up));

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // monitor, count-down instance
   always @(negedge clk) begin
      if (mon_dn) begin
         if (!pulse_dn) begin
            check(count_dn == '0, "R7 down terminal value", int'(count_dn), 0);
            check(sl_dn > 1, "R2 down single-cycle low", sl_dn, 2);
            if (q_dn.size() == 0) begin
               check(1'b0, "R3 down unexpected pulse", sl_dn, 0);
            end else begin
               exp_t e;
               e = q_dn.pop_front();
               check(sl_dn == e.ratio, e.tag, sl_dn, e.ratio);
            end
            sl_dn = 1;
         end else begin
            sl_dn++;
         end
      end
   end

   // monitor, count-up instance
   always @(negedge clk) begin
      if (mon_up) begin
         if (!pulse_up) begin
            check(count_up == ONES, "R7 up terminal value", int'(count_up), int'(ONES));
            check(sl_up > 1, "R2 up single-cycle low", sl_up, 2);
            if (q_up.size() == 0) begin
               check(1'b0, "R4 up unexpected pulse", sl_up, 0);
            end else begin
               exp_t e;
               e = q_up.pop_front();
               check(sl_up == e.ratio, e.tag, sl_up, e.ratio);
            end
            sl_up = 1;
         end else begin
            sl_up++;
         end
      end
   end

   task automatic dn_wait_low();
      @(negedge clk);
      while (pulse_dn) @(negedge clk);
   endtask

   task automatic up_wait_low();
      @(negedge clk);
      while (pulse_up) @(negedge clk);
   endtask

   // driver: at a reload edge set the preset and push the period it must give
   task automatic dn_cycle(input logic [W-1:0] p, input int ratio, input string tag,
                           input int mid_delay, input logic [W-1:0] p_mid);
      dn_wait_low();
      preset_dn = p;
      q_dn.push_back('{ratio, tag});
      if (mid_delay > 0) begin
         repeat (mid_delay) @(negedge clk);
         preset_dn = p_mid;
      end
   endtask

   task automatic up_cycle(input logic [W-1:0] p, input int ratio, input string tag,
                           input int mid_delay, input logic [W-1:0] p_mid);
      up_wait_low();
      preset_up = p;
      q_up.push_back('{ratio, tag});
      if (mid_delay > 0) begin
         repeat (mid_delay) @(negedge clk);
         preset_up = p_mid;
      end
   endtask

   task automatic run_down();
      for (int p = 1; p < (1 << W); p++)
         dn_cycle(W'(p), p + 1, "R3 down period", 0, '0);
      dn_cycle('0, 2, "R6 down preset zero", 0, '0);
      dn_cycle(W'(39), 40, "R5 down mid-period change", 5, W'(7));
      dn_cycle(W'(7), 8, "R5 down new preset at reload", 0, '0);
      dn_wait_low();
      #1 mon_dn = 1'b0;
   endtask

   task automatic run_up();
      for (int r = 2; r <= (1 << W); r++)
         up_cycle(~W'(r - 1), r, "R4 up period", 0, '0);
      up_cycle(ONES, 2, "R6 up preset all ones", 0, '0);
      up_cycle(~W'(39), 40, "R5 up mid-period change", 5, ~W'(7));
      up_cycle(~W'(7), 8, "R5 up new preset at reload", 0, '0);
      up_wait_low();
      #1 mon_up = 1'b0;
   endtask

   initial begin
      preset_dn = W'(5);
      preset_up = ~W'(5);
      repeat (3) @(negedge clk);
      check(pulse_dn == 1'b0, "R1 down pulse low in reset", int'(pulse_dn), 0);
      check(count_dn == '0, "R1 down count in reset", int'(count_dn), 0);
      check(pulse_up == 1'b0, "R1 up pulse low in reset", int'(pulse_up), 0);
      check(count_up == ONES, "R1 up count in reset", int'(count_up), int'(ONES));
      rst_n = 1'b1;
      q_dn.push_back('{6, "R1 down first period"});
      q_up.push_back('{6, "R1 up first period"});
      #1;
      sl_dn = 1;
      sl_up = 1;
      mon_dn = 1'b1;
      mon_up = 1'b1;
      @(negedge clk);
      check(count_dn == W'(5), "R1 down first load", int'(count_dn), 5);
      check(count_up == ~W'(5), "R1 up first load", int'(count_up), int'(~W'(5)));
      fork
         begin
            fork
               run_down();
               run_up();
            join
         end
         begin
            repeat (20000) @(posedge clk);
            check(1'b0, "R3 watchdog expired", 0, 1);
         end
      join_any
      disable fork;
      check(q_dn.size() == 0, "R3 down items left", q_dn.size(), 0);
      check(q_up.size() == 0, "R4 up items left", q_up.size(), 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule